// File: doc/BRIEF.md
# Table-Driven Constant Multiplier Modulo 65537

This block multiplies a stream of 16-bit operands by one fixed 16-bit constant in the ring of integers modulo 2^16+1, with the usual block-cipher convention that the all-zero word stands for 2^16. The constant never enters the datapath as a number. Software precomputes four small tables of partial products and writes them through a load port. Each 4-bit digit of the operand then selects one partial product per cycle. Changing the constant means rewriting the tables. No multiplier array is needed.

The four looked-up partial products are summed through a shifted adder tree into a 32-bit product. That product is folded modulo 2^16+1 by a subtract, compare and select step. A zero operand is resolved from the constant held in the tables. The datapath is split into six register stages and accepts one operand on every clock.

Top module: `const_modmul`

## Requirements
- R1: While rst_ni is low, and until the first operand has passed through the pipeline, out_valid_o is 0. out_data_o is 0 after reset.
- R2: An operand sampled with in_valid_i high at clock edge t yields out_valid_o high with its result after edge t+5 (six register stages). Operands on consecutive edges give results on consecutive edges.
- R3: When tbl_we_i is high at an edge, tbl_data_i (20 bits) is written to row tbl_addr_i of table tbl_sel_i. Table j is indexed by operand bits [4j+3:4j]. The write serves operands sampled on later edges, so the first operand after a reload uses the new constant.
- R4: For a constant K written as "row d holds d*K'" (K' = K, or 65536 when K = 0), a nonzero operand A and nonzero K give out_data_o = (A*K) mod 65537. The reduction takes lo = P[15:0] and hi = P[31:16]; the case lo >= hi yields lo - hi.
- R5: Operand 0 (meaning 2^16) gives (65537 - K') truncated to 16 bits, where K' is read from bits [16:0] of row 1 of table 0.
- R6: Constant 0, with table rows holding d<<16, and a nonzero A give (65537 - A) truncated to 16 bits. A = 1 gives 0.
- R7: Operand 0 with constant 0 gives 1.
- R8: When lo < hi, the result is lo - hi + 65537 truncated to 16 bits. A result equal to 2^16 appears as 0.
- R9: An edge with in_valid_i low yields out_valid_o low after edge t+5. On that edge out_data_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand qualifier |
| in_data_i | input | 16 | Operand, 0 means 2^16 |
| tbl_we_i | input | 1 | Table row write enable |
| tbl_sel_i | input | 2 | Table (digit position) select |
| tbl_addr_i | input | 4 | Row within table |
| tbl_data_i | input | 20 | Partial product to store |
| out_valid_o | output | 1 | Result qualifier |
| out_data_o | output | 16 | Result modulo 65537, 0 means 2^16 |

## Verification
A corrupted table row shows up at the ports only when an operand carries that digit value at that position. The bench therefore streams random operands against several constants, and the next operand with the matching digit gives a wrong result six cycles later. A fault in the fold step shows only on one branch of the lo/hi comparison, or on one of the zero paths. The bench forces both branches with large operand and constant pairs, and it forces operand 0, constant 0 and both together. Every error then appears on the first result that passes through the faulty path. A slip in stage alignment shifts out_valid_o against the expected six-edge delay on the very first operand.

// File: rtl/const_modmul_pkg.sv
package const_modmul_pkg;
  localparam int unsigned OPW_DEF = 16;
  localparam int unsigned DIGW_DEF = 4;

  function automatic int unsigned modulus(input int unsigned opw);
    return (1 << opw) + 1;
  endfunction
endpackage

// File: rtl/cmm_lut_bank.sv
module cmm_lut_bank #(
  parameter int unsigned OPW  = 16,
  parameter int unsigned DIGW = 4,
  localparam int unsigned NDIG = OPW / DIGW,
  localparam int unsigned ROWS = 1 << DIGW,
  localparam int unsigned PPW  = OPW + DIGW,
  localparam int unsigned SELW = $clog2(NDIG)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic [OPW-1:0]             in_data_i,
  input  logic                       tbl_we_i,
  input  logic [SELW-1:0]            tbl_sel_i,
  input  logic [DIGW-1:0]            tbl_addr_i,
  input  logic [PPW-1:0]             tbl_data_i,
  output logic                       valid_o,
  output logic                       zero_o,
  output logic [OPW:0]               kfull_o,
  output logic [NDIG-1:0][PPW-1:0]   pp_o
);
  logic [PPW-1:0] tbl_q [NDIG][ROWS];

  for (genvar j = 0; j < NDIG; j++) begin : g_tbl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < ROWS; r++) tbl_q[j][r] <= '0;
      end else if (tbl_we_i && tbl_sel_i == SELW'(j)) begin
        tbl_q[j][tbl_addr_i] <= tbl_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pp_o[j] <= '0;
      else         pp_o[j] <= tbl_q[j][in_data_i[j*DIGW +: DIGW]];
    end
  end

  // row 1 of table 0 holds the constant itself (0 encoded as 2^OPW)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      zero_o  <= 1'b0;
      kfull_o <= '0;
    end else begin
      valid_o <= in_valid_i;
      zero_o  <= (in_data_i == '0);
      kfull_o <= tbl_q[0][1][OPW:0];
    end
  end
endmodule

// File: rtl/cmm_sum.sv
module cmm_sum #(
  parameter int unsigned OPW  = 16,
  parameter int unsigned DIGW = 4,
  localparam int unsigned NDIG = OPW / DIGW,
  localparam int unsigned PPW  = OPW + DIGW,
  localparam int unsigned PRW  = PPW + DIGW,
  localparam int unsigned NPR  = NDIG / 2,
  localparam int unsigned PW   = 2 * OPW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     zero_i,
  input  logic [OPW:0]             kfull_i,
  input  logic [NDIG-1:0][PPW-1:0] pp_i,
  output logic                     valid_o,
  output logic                     zero_o,
  output logic [OPW:0]             kfull_o,
  output logic [PW-1:0]            prod_o
);
  // tree is two levels: digit pairs, then the two pair sums (NDIG = 4)
  logic [NPR-1:0][PRW-1:0] pair_q;
  logic                    v2_q, z2_q;
  logic [OPW:0]            k2_q;

  for (genvar k = 0; k < NPR; k++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pair_q[k] <= '0;
      else pair_q[k] <= PRW'(pp_i[2*k]) + (PRW'(pp_i[2*k+1]) << DIGW);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q <= 1'b0; z2_q <= 1'b0; k2_q <= '0;
      valid_o <= 1'b0; zero_o <= 1'b0; kfull_o <= '0; prod_o <= '0;
    end else begin
      v2_q    <= valid_i;
      z2_q    <= zero_i;
      k2_q    <= kfull_i;
      valid_o <= v2_q;
      zero_o  <= z2_q;
      kfull_o <= k2_q;
      prod_o  <= PW'(pair_q[0]) + (PW'(pair_q[1]) << (2 * DIGW));
    end
  end
endmodule

// File: rtl/cmm_reduce.sv
module cmm_reduce #(
  parameter int unsigned OPW = 16,
  localparam int unsigned PW = 2 * OPW,
  localparam logic [OPW:0] MOD = {1'b1, {(OPW-1){1'b0}}, 1'b1}
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic           zero_i,
  input  logic [OPW:0]   kfull_i,
  input  logic [PW-1:0]  prod_i,
  output logic           valid_o,
  output logic [OPW-1:0] data_o
);
  logic [OPW-1:0] lo, hi;
  logic           v4_q, z4_q, ge4_q, v5_q;
  logic [OPW:0]   diff4_q, alt4_q, res5_q, res5_d;

  assign lo = prod_i[OPW-1:0];
  assign hi = prod_i[PW-1:OPW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v4_q <= 1'b0; z4_q <= 1'b0; ge4_q <= 1'b0;
      diff4_q <= '0; alt4_q <= '0;
    end else begin
      v4_q    <= valid_i;
      z4_q    <= zero_i;
      ge4_q   <= (lo >= hi);
      diff4_q <= {1'b0, lo} - {1'b0, hi};
      alt4_q  <= MOD - kfull_i;
    end
  end

  // negative difference wraps in OPW+1 bits; adding MOD lands in range
  always_comb begin
    if (z4_q)       res5_d = alt4_q;
    else if (ge4_q) res5_d = diff4_q;
    else            res5_d = diff4_q + MOD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v5_q <= 1'b0; res5_q <= '0; valid_o <= 1'b0; data_o <= '0;
    end else begin
      v5_q    <= v4_q;
      res5_q  <= res5_d;
      valid_o <= v5_q;
      if (v5_q) data_o <= res5_q[OPW-1:0];
    end
  end

  // R8
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v4_q && !z4_q) |=> (res5_q <= {1'b1, {OPW{1'b0}}}));

  // R4
  fold_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !zero_i && lo >= hi) |=> ##1 (res5_q <= {1'b0, $past(lo, 2)}));
endmodule

// File: rtl/const_modmul.sv
module const_modmul #(
  parameter int unsigned OPW  = const_modmul_pkg::OPW_DEF,
  parameter int unsigned DIGW = const_modmul_pkg::DIGW_DEF,
  localparam int unsigned NDIG = OPW / DIGW,
  localparam int unsigned PPW  = OPW + DIGW,
  localparam int unsigned SELW = $clog2(NDIG),
  localparam int unsigned PW   = 2 * OPW,
  localparam int unsigned LAT  = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [OPW-1:0]  in_data_i,
  input  logic            tbl_we_i,
  input  logic [SELW-1:0] tbl_sel_i,
  input  logic [DIGW-1:0] tbl_addr_i,
  input  logic [PPW-1:0]  tbl_data_i,
  output logic            out_valid_o,
  output logic [OPW-1:0]  out_data_o
);
  logic                     v1, z1, v3, z3;
  logic [OPW:0]             k1, k3;
  logic [NDIG-1:0][PPW-1:0] pp1;
  logic [PW-1:0]            prod3;

  cmm_lut_bank #(.OPW(OPW), .DIGW(DIGW)) u_lut (
    .clk_i, .rst_ni, .in_valid_i, .in_data_i,
    .tbl_we_i, .tbl_sel_i, .tbl_addr_i, .tbl_data_i,
    .valid_o(v1), .zero_o(z1), .kfull_o(k1), .pp_o(pp1)
  );

  cmm_sum #(.OPW(OPW), .DIGW(DIGW)) u_sum (
    .clk_i, .rst_ni, .valid_i(v1), .zero_i(z1), .kfull_i(k1), .pp_i(pp1),
    .valid_o(v3), .zero_o(z3), .kfull_o(k3), .prod_o(prod3)
  );

  cmm_reduce #(.OPW(OPW)) u_red (
    .clk_i, .rst_ni, .valid_i(v3), .zero_i(z3), .kfull_i(k3), .prod_i(prod3),
    .valid_o(out_valid_o), .data_o(out_data_o)
  );

  // cycles since reset, saturating at the pipeline depth (checks only)
  logic [$clog2(LAT+1)-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 age_q <= '0;
    else if (age_q != LAT[$clog2(LAT+1)-1:0]) age_q <= age_q + 1'b1;
  end

  // R1
  fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (age_q == LAT[$clog2(LAT+1)-1:0]));

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == LAT[$clog2(LAT+1)-1:0]) |-> (out_valid_o == $past(in_valid_i, 6)));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == LAT[$clog2(LAT+1)-1:0] && !out_valid_o) |=> ($stable(out_data_o) || out_valid_o));
endmodule

// File: tb/const_modmul_test.sv
module const_modmul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_sel = '0;
  logic [3:0]  tbl_addr = '0;
  logic [19:0] tbl_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0, fresh = 0;
  logic [15:0] cur_k = '0;

  logic        ev [6];
  logic [15:0] ed [6];
  int          et [6];
  logic [15:0] last_d = '0;

  always #10 clk = ~clk;

  const_modmul uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .tbl_we_i(tbl_we), .tbl_sel_i(tbl_sel), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  function automatic longint widen(logic [15:0] v);
    return (v == 0) ? 64'd65536 : longint'(v);
  endfunction

  function automatic logic [15:0] ref_mul(logic [15:0] a, logic [15:0] k);
    longint r = (widen(a) * widen(k)) % 65537;
    return r[15:0];
  endfunction

  function automatic int classify(logic [15:0] a, logic [15:0] k, bit f);
    longint p = widen(a) * widen(k);
    if (a == 0 && k == 0) return 7;
    if (a == 0) return 5;
    if (k == 0) return 6;
    if (f) return 3;
    if ((p & 64'hFFFF) < (p >> 16)) return 8;
    return 4;
  endfunction

  function automatic string tag_name(int t);
    case (t)
      3: return "R3";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R4";
    endcase
  endfunction

  // reference pipeline, six edges deep
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin ev[i] <= 1'b0; ed[i] <= '0; et[i] <= 0; end
    end else begin
      for (int i = 5; i > 0; i--) begin ev[i] <= ev[i-1]; ed[i] <= ed[i-1]; et[i] <= et[i-1]; end
      ev[0] <= in_valid;
      ed[0] <= ref_mul(in_data, cur_k);
      et[0] <= classify(in_data, cur_k, fresh);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (out_valid !== ev[5]) begin
        bad++;
        $display("FAIL R2 valid: got %0b exp %0b", out_valid, ev[5]);
      end
      total++;
      if (ev[5]) begin
        if (out_data !== ed[5]) begin
          bad++;
          $display("FAIL %s data: got %h exp %h", tag_name(et[5]), out_data, ed[5]);
        end
        last_d = ed[5];
      end else if (out_data !== last_d) begin
        bad++;
        $display("FAIL R9 hold: got %h exp %h", out_data, last_d);
      end
    end
  end

  task automatic load_const(logic [15:0] k);
    longint kk = widen(k);
    for (int j = 0; j < 4; j++)
      for (int d = 0; d < 16; d++) begin
        @(negedge clk);
        in_valid = 1'b0;
        tbl_we = 1'b1; tbl_sel = 2'(j); tbl_addr = 4'(d);
        tbl_data = 20'(longint'(d) * kk);
      end
    @(negedge clk);
    tbl_we = 1'b0;
    cur_k = k;
  endtask

  task automatic stream(int n, int mode);
    logic [15:0] corners [6] = '{16'h0000, 16'h0001, 16'h0002, 16'hFFFF, 16'h8000, 16'h7FFF};
    fresh = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 1) fresh = 0;
      case (mode)
        0: begin in_valid = (i == 0) || ($urandom_range(3) != 0); in_data = 16'($urandom); end
        1: begin in_valid = 1'b1; in_data = corners[i % 6]; end
        default: begin in_valid = 1'b1; in_data = 16'($urandom); end
      endcase
      if (!in_valid) in_data = 16'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b0;
    fresh = 0;
    repeat (7) @(negedge clk);
  endtask

  initial begin
    logic [15:0] consts [7] = '{16'h0001, 16'h0000, 16'hFFFF, 16'h8001, 16'h1234, 16'h0002, 16'hBEEF};
    repeat (3) @(negedge clk);
    // R1 reset values
    total++;
    if (out_valid !== 1'b0 || out_data !== 16'h0) begin
      bad++;
      $display("FAIL R1 reset: got %0b/%h exp 0/0000", out_valid, out_data);
    end
    rst_n = 1'b1;
    foreach (consts[c]) begin
      load_const(consts[c]);
      stream(12, 1);
      stream(60, 0);
      stream(60, 2);
    end
    for (int c = 0; c < 6; c++) begin
      load_const(16'($urandom));
      stream(150, 0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule